// File: doc/BRIEF.md
# Oversampled Serial Receiver with Standby Wakeup

This block receives asynchronous serial frames on one input line. A baud strobe at sixteen times the bit rate paces it. A falling edge on the line starts a frame. The three samples around the middle of each bit are voted to give the bit value. The data bits arrive least significant bit first. A frame has 8 data bits, or 9 when the long-frame setting is on, and then a stop bit. When a frame completes, the word moves into a data register and a set of status flags is updated for the host.

The host controls the block through a control write strobe. That strobe loads the receiver enable, the standby request, the wake-method select, the frame length and two interrupt enables. Two read strobes mark a host read of the status byte and a host read of the data register. When the standby request is set, the receiver ignores all traffic until its wake condition occurs. The hardware then clears the request by itself. Because of this, a node on a shared line can skip messages that are addressed to other nodes.

Top module: `uart_rx_wake`

## Requirements
- R1: Reset clears the data register, all flags, the receiver enable and the standby request. While the enable is 0, frames on the line change no flag and no data.
- R2: Clearing the enable keeps every flag that is already set, and it forces the interrupt output to 0. Setting the enable again brings the interrupt back.
- R3: Each bit is the majority of oversamples 7, 8 and 9 of that bit. Data is taken LSB first. A completed frame loads the data register and sets ready, which is status bit 5.
- R4: Any disagreement among the three votes of any bit in an accepted frame sets noise, which is status bit 2.
- R5: A stop bit that votes 0 sets framing error, which is status bit 1.
- R6: If a frame completes while ready is still set, overrun (status bit 3) is set. The data register keeps its older word.
- R7: Flags are cleared only by a status read followed by a data read. The data read clears only the flags that were set at that status read. A data read alone clears nothing.
- R8: Idle (status bit 4) sets after 16×(data bits+2) oversample ticks of continuous 1s that follow an accepted frame. It does not set earlier. It sets at most once per accepted frame.
- R9: While the standby request is set, completed frames change neither the data register nor any flag. Only a control write can set the request.
- R10: With wake select 0, a full frame time of 1s on the line, counted from standby entry or from the last activity, clears the standby request. The next frame is then received.
- R11: With wake select 1, only a frame whose most significant data bit is 1 clears the standby request, and that frame is received. A frame whose top bit is 0 does not wake the receiver, and neither does an idle line.
- R12: In 9-bit mode, the ninth data bit is returned in data bit 8. In 8-bit mode, data bit 8 reads 0.
- R13: The status byte is {0, 0, ready, idle, overrun, noise, framing, 0}. The interrupt output, one cycle later, is enable AND ((rx_ie AND (ready OR overrun)) OR (idle_ie AND idle)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Oversample strobe, 16 per bit time |
| rx_in | input | 1 | Serial line, idle high |
| ctrl_wr | input | 1 | Control write strobe |
| wr_enable | input | 1 | Receiver enable value |
| wr_standby | input | 1 | Standby request value |
| wr_wake_addr | input | 1 | Wake select: 0 idle line, 1 address mark |
| wr_nine | input | 1 | 1 selects 9 data bits |
| wr_rx_ie | input | 1 | Interrupt enable for ready and overrun |
| wr_idle_ie | input | 1 | Interrupt enable for idle |
| stat_rd | input | 1 | Host read of the status byte |
| data_rd | input | 1 | Host read of the data register |
| rx_data_o | output | 9 | Received data register |
| status_o | output | 8 | Status byte |
| enable_o | output | 1 | Current receiver enable |
| standby_o | output | 1 | Current standby request |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach is the exit from standby. It depends on how long the line has been idle, counted from the moment standby was entered. An address-marked wake also has to land in the same cycle that the waking frame is accepted. The stimulus puts a frame on the line right after standby entry. It then holds the line high for longer than a frame time and checks the standby bit before and after the wake. For address wake, it sends a frame with the top bit clear, then a noisy frame, then a long idle gap. Only after these does it send the marked frame, and it checks that this frame alone wakes the receiver and is received.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic {ST_HUNT, ST_RUN} rx_state_e;
  // flag vector positions; status byte bits 5..1 carry flags 4..0
  localparam int F_FE = 0;
  localparam int F_NF = 1;
  localparam int F_OV = 2;
  localparam int F_ID = 3;
  localparam int F_RD = 4;
  localparam int NFLAG = 5;
endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rx_s,
  input  logic          enable,
  input  logic          nine,
  input  logic          idle_restart,
  output logic          done,
  output logic [DW:0]   frame_data,
  output logic          frame_noise,
  output logic          frame_ferr,
  output logic          idle_hit
);
  localparam int CW  = $clog2(OSR);
  localparam int BW  = $clog2(DW + 3);
  localparam int IW  = $clog2((DW + 3) * OSR + 1);
  localparam int MID = OSR / 2;

  rx_state_e      st;
  logic [CW-1:0]  cnt;
  logic [BW-1:0]  bitn;
  logic [DW:0]    shreg;
  logic           s_a, s_b, noise;
  logic [IW-1:0]  icnt;
  logic [BW-1:0]  stop_idx;
  logic [IW-1:0]  lim;
  logic           vote, split;

  assign stop_idx = nine ? BW'(DW + 2) : BW'(DW + 1);
  assign lim      = nine ? IW'((DW + 3) * OSR) : IW'((DW + 2) * OSR);
  assign vote     = (s_a & s_b) | (s_a & rx_s) | (s_b & rx_s);
  assign split    = !((s_a == s_b) && (s_b == rx_s));

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      st          <= ST_HUNT;
      cnt         <= '0;
      bitn        <= '0;
      shreg       <= '0;
      s_a         <= 1'b1;
      s_b         <= 1'b1;
      noise       <= 1'b0;
      done        <= 1'b0;
      frame_data  <= '0;
      frame_noise <= 1'b0;
      frame_ferr  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (st)
          ST_HUNT: begin
            if (!rx_s) begin
              st    <= ST_RUN;
              cnt   <= CW'(1);
              bitn  <= '0;
              noise <= 1'b0;
            end
          end
          default: begin
            if (cnt == CW'(OSR - 1)) begin
              cnt  <= '0;
              bitn <= bitn + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
            if (cnt == CW'(MID - 2)) s_a <= rx_s;
            if (cnt == CW'(MID - 1)) s_b <= rx_s;
            if (cnt == CW'(MID)) begin
              if (bitn == '0) begin
                if (vote) st <= ST_HUNT;
                else noise <= split;
              end else if (bitn == stop_idx) begin
                done        <= 1'b1;
                frame_data  <= nine ? shreg : {1'b0, shreg[DW:1]};
                frame_noise <= noise | split;
                frame_ferr  <= !vote;
                st          <= ST_HUNT;
              end else begin
                shreg <= {vote, shreg[DW:1]};
                noise <= noise | split;
              end
            end
          end
        endcase
      end
    end
  end

  // run length of 1s on the line while hunting
  always_ff @(posedge clk) begin
    if (rst || !enable || idle_restart) begin
      icnt     <= '0;
      idle_hit <= 1'b0;
    end else begin
      idle_hit <= 1'b0;
      if (tick) begin
        if (st != ST_HUNT || !rx_s) begin
          icnt <= '0;
        end else if (icnt != lim) begin
          icnt <= icnt + 1'b1;
          if (icnt == lim - 1'b1) idle_hit <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             standby,
  input  logic             wake_addr,
  input  logic             nine,
  input  logic             done,
  input  logic [DW:0]      frame_data,
  input  logic             frame_noise,
  input  logic             frame_ferr,
  input  logic             idle_hit,
  input  logic             stat_rd,
  input  logic             data_rd,
  output logic [NFLAG-1:0] flags,
  output logic [DW:0]      data_q,
  output logic             wake
);
  logic [NFLAG-1:0] seen, nxt, nxt_seen;
  logic [DW:0]      nxt_data;
  logic             armed, nxt_armed, mark, accept;

  assign mark   = nine ? frame_data[DW] : frame_data[DW-1];
  assign accept = done && (!standby || (wake_addr && mark));
  assign wake   = standby && ((wake_addr && done && mark) ||
                              (!wake_addr && idle_hit));

  always_comb begin
    nxt       = flags;
    nxt_seen  = seen;
    nxt_data  = data_q;
    nxt_armed = armed;
    if (stat_rd) nxt_seen = flags;
    if (data_rd) begin
      nxt      = nxt & ~seen;
      nxt_seen = '0;
    end
    if (accept) begin
      nxt_armed = 1'b1;
      if (flags[F_RD]) begin
        nxt[F_OV] = 1'b1;
      end else begin
        nxt[F_RD] = 1'b1;
        nxt[F_NF] = frame_noise;
        nxt[F_FE] = frame_ferr;
        nxt_data  = frame_data;
      end
    end
    if (idle_hit) begin
      if (armed && !standby) nxt[F_ID] = 1'b1;
      nxt_armed = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags  <= '0;
      seen   <= '0;
      data_q <= '0;
      armed  <= 1'b0;
    end else begin
      flags  <= nxt;
      seen   <= nxt_seen;
      data_q <= nxt_data;
      armed  <= nxt_armed;
    end
  end
endmodule

// File: rtl/uart_rx_wake.sv
module uart_rx_wake
  import uart_rx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick16,
  input  logic        rx_in,
  input  logic        ctrl_wr,
  input  logic        wr_enable,
  input  logic        wr_standby,
  input  logic        wr_wake_addr,
  input  logic        wr_nine,
  input  logic        wr_rx_ie,
  input  logic        wr_idle_ie,
  input  logic        stat_rd,
  input  logic        data_rd,
  output logic [DW:0] rx_data_o,
  output logic [7:0]  status_o,
  output logic        enable_o,
  output logic        standby_o,
  output logic        irq_o
);
  logic [1:0]       sync;
  logic             en_q, sb_q, wsel_q, nine_q, rie_q, iie_q, irq_q;
  logic             done, fnoise, fferr, idle_hit, wake, restart;
  logic [DW:0]      fdata, data_q;
  logic [NFLAG-1:0] flags;

  assign restart = ctrl_wr && wr_standby && !sb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync   <= 2'b11;
      en_q   <= 1'b0;
      sb_q   <= 1'b0;
      wsel_q <= 1'b0;
      nine_q <= 1'b0;
      rie_q  <= 1'b0;
      iie_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      sync <= {sync[0], rx_in};
      if (ctrl_wr) begin
        en_q   <= wr_enable;
        sb_q   <= wr_standby;
        wsel_q <= wr_wake_addr;
        nine_q <= wr_nine;
        rie_q  <= wr_rx_ie;
        iie_q  <= wr_idle_ie;
      end else if (wake) begin
        sb_q <= 1'b0;
      end
      irq_q <= en_q && ((rie_q && (flags[F_RD] || flags[F_OV])) ||
                        (iie_q && flags[F_ID]));
    end
  end

  uart_rx_sampler #(.DW(DW), .OSR(OSR)) u_sampler (
    .clk(clk), .rst(rst), .tick(tick16), .rx_s(sync[1]), .enable(en_q),
    .nine(nine_q), .idle_restart(restart), .done(done), .frame_data(fdata),
    .frame_noise(fnoise), .frame_ferr(fferr), .idle_hit(idle_hit)
  );

  uart_rx_status #(.DW(DW)) u_status (
    .clk(clk), .rst(rst), .standby(sb_q), .wake_addr(wsel_q), .nine(nine_q),
    .done(done), .frame_data(fdata), .frame_noise(fnoise), .frame_ferr(fferr),
    .idle_hit(idle_hit), .stat_rd(stat_rd), .data_rd(data_rd),
    .flags(flags), .data_q(data_q), .wake(wake)
  );

  assign rx_data_o = data_q;
  assign status_o  = {2'b00, flags, 1'b0};
  assign enable_o  = en_q;
  assign standby_o = sb_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/uart_rx_wake_chk.sv
module uart_rx_wake_chk #(
  parameter int DW = 8
) (
  input logic        clk,
  input logic        rst,
  input logic        ctrl_wr,
  input logic        data_rd,
  input logic [DW:0] rx_data_o,
  input logic [7:0]  status_o,
  input logic        enable_o,
  input logic        standby_o,
  input logic        irq_o
);
  // R7
  flag_clear_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
    (|($past(status_o[5:1]) & ~status_o[5:1])) |-> $past(data_rd));
  // R2
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(enable_o));
  // R6
  overrun_keeps_data_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[3]) |-> $stable(rx_data_o));
  // R6
  overrun_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[3]) |-> $past(status_o[5]));
  // R9
  standby_blocks_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[5]) |-> !standby_o);
  // R9
  standby_by_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(standby_o) |-> $past(ctrl_wr));
endmodule

bind uart_rx_wake uart_rx_wake_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .data_rd(data_rd),
  .rx_data_o(rx_data_o), .status_o(status_o), .enable_o(enable_o),
  .standby_o(standby_o), .irq_o(irq_o)
);

// File: tb/uart_rx_wake_bench.sv
module uart_rx_wake_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {nine, data[8:0], glitch, bad_stop}
  localparam logic [11:0] VEC [NVEC] = '{
    {1'b0, 9'h0A5, 1'b0, 1'b0},
    {1'b0, 9'h13C, 1'b0, 1'b0},
    {1'b0, 9'h0FF, 1'b1, 1'b0},
    {1'b0, 9'h000, 1'b0, 1'b1},
    {1'b1, 9'h155, 1'b0, 1'b0},
    {1'b1, 9'h0C3, 1'b1, 1'b1}
  };

  logic clk = 0, rst = 1, tick16 = 1, rx_in = 1;
  logic ctrl_wr = 0, wr_enable = 0, wr_standby = 0, wr_wake_addr = 0;
  logic wr_nine = 0, wr_rx_ie = 0, wr_idle_ie = 0, stat_rd = 0, data_rd = 0;
  logic [8:0] rx_data_o;
  logic [7:0] status_o;
  logic enable_o, standby_o, irq_o;
  int n_chk = 0, n_fail = 0, cyc = 0;

  uart_rx_wake u_uart_rx_wake (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_ctrl(input logic en, sb, wa, nine, rie, iie);
    @(negedge clk);
    ctrl_wr = 1; wr_enable = en; wr_standby = sb; wr_wake_addr = wa;
    wr_nine = nine; wr_rx_ie = rie; wr_idle_ie = iie;
    @(negedge clk);
    ctrl_wr = 0;
  endtask

  task automatic clear_seq();
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0; data_rd = 1;
    @(negedge clk); data_rd = 0;
  endtask

  task automatic send(input logic [8:0] d, input logic nine, input logic glitch, input logic bad_stop);
    int nb;
    nb = nine ? 9 : 8;
    for (int c = 0; c < 16; c++) begin rx_in = 0; @(negedge clk); end
    for (int b = 0; b < nb; b++)
      for (int c = 0; c < 16; c++) begin
        rx_in = (glitch && b == 3 && c == 7) ? ~d[b] : d[b];
        @(negedge clk);
      end
    for (int c = 0; c < 16; c++) begin rx_in = !bad_stop; @(negedge clk); end
    rx_in = 1;
    wait_cyc(2);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    wait_cyc(3);
    rst = 0;
    wait_cyc(1);
    check("R1 reset status", status_o, 8'h00);
    check("R1 reset data", rx_data_o, 9'h000);
    check("R1 reset enable", enable_o, 0);
    check("R1 reset standby", standby_o, 0);
    check("R13 reset irq", irq_o, 0);

    // disabled receiver ignores the line
    send(9'h05A, 0, 0, 0);
    check("R1 disabled no ready", status_o, 8'h00);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      logic [11:0] e;
      logic [8:0] expd;
      e = VEC[v];
      expd = e[11] ? e[10:2] : {1'b0, e[9:2]};
      write_ctrl(1, 0, 0, e[11], 0, 0);
      send(e[10:2], e[11], e[1], e[0]);
      check("R3 ready set", status_o[5], 1);
      check("R12 R3 data", rx_data_o, expd);
      check("R4 noise", status_o[2], e[1]);
      check("R5 framing", status_o[1], e[0]);
      clear_seq();
      check("R7 cleared", status_o, 8'h00);
    end

    // interrupt, layout, overrun, disable keeps flags
    write_ctrl(1, 0, 0, 0, 1, 0);
    send(9'h05A, 0, 0, 0);
    wait_cyc(1);
    check("R13 layout ready only", status_o, 8'h20);
    check("R13 irq on ready", irq_o, 1);
    send(9'h077, 0, 0, 0);
    check("R6 overrun set", status_o, 8'h28);
    check("R6 old data kept", rx_data_o, 9'h05A);
    write_ctrl(0, 0, 0, 0, 1, 0);
    wait_cyc(1);
    check("R2 flags kept on disable", status_o, 8'h28);
    check("R2 irq off when disabled", irq_o, 0);
    write_ctrl(1, 0, 0, 0, 1, 0);
    wait_cyc(1);
    check("R2 irq back on enable", irq_o, 1);
    @(negedge clk); data_rd = 1; @(negedge clk); data_rd = 0;
    check("R7 data read alone keeps flags", status_o, 8'h28);
    clear_seq();
    check("R7 sequence clears", status_o, 8'h00);

    // idle flag timing
    write_ctrl(1, 0, 0, 0, 0, 1);
    send(9'h011, 0, 0, 0);
    clear_seq();
    wait_cyc(100);
    check("R8 idle not early", status_o[4], 0);
    wait_cyc(80);
    check("R8 idle set", status_o[4], 1);
    check("R13 irq on idle", irq_o, 1);
    clear_seq();
    wait_cyc(250);
    check("R8 idle once per frame", status_o[4], 0);

    // standby, idle wake
    write_ctrl(1, 1, 0, 0, 0, 0);
    check("R9 standby set", standby_o, 1);
    send(9'h03C, 0, 1, 1);
    check("R9 frame ignored", status_o, 8'h00);
    check("R9 data unchanged", rx_data_o, 9'h011);
    check("R10 still standby", standby_o, 1);
    wait_cyc(200);
    check("R10 idle wake", standby_o, 0);
    check("R10 no idle flag", status_o, 8'h00);
    send(9'h066, 0, 0, 0);
    check("R10 receives after wake", rx_data_o, 9'h066);
    clear_seq();

    // standby, address wake
    write_ctrl(1, 1, 1, 0, 0, 0);
    send(9'h035, 0, 0, 0);
    check("R11 unmarked ignored", status_o, 8'h00);
    check("R11 unmarked no wake", standby_o, 1);
    send(9'h004, 0, 1, 0);
    check("R9 noise suppressed", status_o, 8'h00);
    wait_cyc(200);
    check("R11 idle no wake", standby_o, 1);
    send(9'h0A5, 0, 0, 0);
    check("R11 marked wakes", standby_o, 0);
    check("R11 marked received", status_o, 8'h20);
    check("R11 marked data", rx_data_o, 9'h0A5);
    clear_seq();

    // 9-bit address mark uses bit 8
    write_ctrl(1, 1, 1, 1, 0, 0);
    send(9'h0FF, 1, 0, 0);
    check("R12 R11 bit7 not mark in 9-bit", standby_o, 1);
    send(9'h101, 1, 0, 0);
    check("R12 R11 bit8 mark", rx_data_o, 9'h101);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule